// File: doc/BRIEF.md
# Command-Driven Two-Wire Byte Master

This block is the serial engine behind a processor-facing two-wire (I2C-style) master. Software sees two registers: an 8-bit data register and a control/status register. Writing a 4-bit command to the control register starts exactly one bus action. The action is one of a START condition, a STOP condition, a byte transmit, a byte receive that is acknowledged, or a final byte receive that is not acknowledged. A busy flag, two active-low acknowledge flags, an error flag and a one-cycle completion pulse let the processor follow progress.

The serial clock comes from a divider on the system clock. Each bit occupies four quarter-phases of `QTR_CYC` system cycles. SCK is low in quarters 0 and 1 and released high in quarters 2 and 3. SDA moves only at the end of quarter 0, while SCK is low. The one exception is the deliberate SDA edge at the end of quarter 2 that forms a START or STOP.

After a byte transmit or receive, SCK keeps toggling with SDA held. It only comes to rest high when software writes the no-op command. Both lines are open-drain: the block drives only "pull low" enables and reads SDA back through a separate input.

Top module: `twi_cmd_master`

## Requirements
- R1: After reset the status byte reads 0x30, so that bit 7 error=0, bit 6 busy=0, bit 5 slave-ack flag=1 and bit 4 master-ack flag=1, with bits 3:0 reading 0. In the same state the data register reads 0x00, the interrupt is low and neither line is pulled.
- R2: Command 1001 makes SDA fall while SCK is high (START). Command 0101 makes SDA rise while SCK is high (STOP). Both leave SCK resting high.
- R3: Command 0011 shifts the data register out MSB first on eight clocks and releases SDA on a ninth. Bit 5 of the status byte takes the SDA level sampled on that ninth clock, so 0 means the slave acknowledged.
- R4: Command 0010 shifts in eight bits MSB first and places them in the data register by the time busy falls. The master pulls SDA low on the ninth clock, and bit 4 of the status byte becomes 0.
- R5: Command 0110 receives a byte like R4, but releases SDA on the ninth clock (no acknowledge) and sets bit 4 of the status byte to 1.
- R6: Busy (status bit 6) is 1 from the accepted write until the action ends. The interrupt output pulses high for exactly one cycle each time busy falls.
- R7: Any command code outside the six listed (0000, 0010, 0011, 0101, 0110, 1001) causes no bus activity and no interrupt, and sets status bit 7. Status bit 7 is cleared by the next accepted command, including the no-op.
- R8: A command written while busy is 1 is ignored and sets status bit 7. The action in progress completes unchanged.
- R9: A write to the data register while busy is 1 is ignored.
- R10: After a byte transmit or receive, SCK keeps toggling with a period of 4*QTR_CYC system cycles. Command 0000 stops it with SCK resting high. After START or STOP, SCK rests high without a no-op.
- R11: During byte actions SDA changes only while SCK is low, so no spurious START or STOP appears on the bus.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| data_wr | input | 1 | Write strobe for the data register |
| data_wdata | input | 8 | Data register write value |
| ctrl_wr | input | 1 | Write strobe for the command field |
| ctrl_cmd | input | 4 | Command code |
| data_rdata | output | 8 | Data register read value |
| status | output | 8 | {error, busy, slave-ack_n, master-ack_n, 4'b0} |
| done_irq | output | 1 | One-cycle pulse when busy falls |
| scl_pull | output | 1 | 1 pulls SCK low, 0 releases it |
| sda_pull | output | 1 | 1 pulls SDA low, 0 releases it |
| sda_in | input | 1 | Resolved SDA line level |

## Verification
The hardest situation to reach is a second command arriving in the middle of a running byte. Both the rejection and the intact completion of the first action must then be observed on the pins. The bench starts a transmit against a modelled slave that acknowledges. Partway through the shift it writes a new data value and a START command. It then checks that the error and busy flags are both set at once, that the captured byte is the original one, and that the data register kept its value. The free-running clock after a byte, and its stop by the no-op, are measured by counting SCK falling edges on the pin across fixed cycle windows.

// File: rtl/twi_cmd_master.sv
module twi_cmd_master #(
  parameter int QTR_CYC = 160
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       data_wr,
  input  logic [7:0] data_wdata,
  input  logic       ctrl_wr,
  input  logic [3:0] ctrl_cmd,
  output logic [7:0] data_rdata,
  output logic [7:0] status,
  output logic       done_irq,
  output logic       scl_pull,
  output logic       sda_pull,
  input  logic       sda_in
);
  localparam int CW = (QTR_CYC > 1) ? $clog2(QTR_CYC) : 1;
  localparam logic [CW-1:0] QLAST = CW'(QTR_CYC - 1);
  localparam logic [3:0] C_NOP = 4'b0000, C_RXA = 4'b0010, C_TX = 4'b0011,
                         C_STOP = 4'b0101, C_RXL = 4'b0110, C_START = 4'b1001;

  typedef enum logic [1:0] {OP_START, OP_STOP, OP_TX, OP_RX} op_t;

  logic [CW-1:0] qcnt;
  logic [1:0]    phase;
  logic [3:0]    bitn;
  op_t           op;
  logic          nack, busy, run, err, rx_ack_n, tx_ack_n;
  logic [7:0]    dreg, shreg;

  logic legal, accept, nop, reject, qend, last_slot, finish;

  assign legal     = ctrl_cmd inside {C_NOP, C_RXA, C_TX, C_STOP, C_RXL, C_START};
  assign accept    = ctrl_wr && !busy && legal && (ctrl_cmd != C_NOP);
  assign nop       = ctrl_wr && !busy && (ctrl_cmd == C_NOP);
  assign reject    = ctrl_wr && (busy || !legal);
  assign qend      = (busy || run) && (qcnt == QLAST);
  assign last_slot = (op == OP_START) || (op == OP_STOP) || (bitn == 4'd8);
  assign finish    = busy && qend && (phase == 2'd3) && last_slot;

  assign scl_pull   = (busy || run) && !phase[1];
  assign status     = {err, busy, rx_ack_n, tx_ack_n, 4'b0000};
  assign data_rdata = dreg;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      qcnt     <= '0;
      phase    <= 2'd0;
      bitn     <= 4'd0;
      op       <= OP_START;
      nack     <= 1'b0;
      busy     <= 1'b0;
      run      <= 1'b0;
      err      <= 1'b0;
      rx_ack_n <= 1'b1;
      tx_ack_n <= 1'b1;
      dreg     <= 8'h00;
      shreg    <= 8'h00;
      sda_pull <= 1'b0;
      done_irq <= 1'b0;
    end else begin
      done_irq <= finish;
      if (data_wr && !busy) dreg <= data_wdata;
      if (reject) err <= 1'b1;
      else if (accept || nop) err <= 1'b0;
      if (nop) run <= 1'b0;

      if (accept) begin
        busy  <= 1'b1;
        run   <= 1'b0;
        qcnt  <= '0;
        phase <= 2'd0;
        bitn  <= 4'd0;
        shreg <= dreg;
        nack  <= (ctrl_cmd == C_RXL);
        case (ctrl_cmd)
          C_START: op <= OP_START;
          C_STOP:  op <= OP_STOP;
          C_TX:    op <= OP_TX;
          default: op <= OP_RX;
        endcase
      end else if (busy || run) begin
        if (qend) begin
          qcnt  <= '0;
          phase <= phase + 2'd1;
        end else begin
          qcnt <= qcnt + 1'b1;
        end
        if (busy && qend) begin
          case (phase)
            2'd0: begin
              case (op)
                OP_START: sda_pull <= 1'b0;
                OP_STOP:  sda_pull <= 1'b1;
                OP_TX:    sda_pull <= (bitn < 4'd8) ? !shreg[7] : 1'b0;
                default:  sda_pull <= (bitn == 4'd8) ? !nack : 1'b0;
              endcase
            end
            2'd2: begin
              case (op)
                OP_START: sda_pull <= 1'b1;
                OP_STOP:  sda_pull <= 1'b0;
                OP_TX:    if (bitn == 4'd8) rx_ack_n <= sda_in;
                default:  if (bitn < 4'd8) shreg <= {shreg[6:0], sda_in};
              endcase
            end
            2'd3: begin
              if (op == OP_TX && bitn < 4'd8) shreg <= {shreg[6:0], 1'b0};
              if (last_slot) begin
                busy <= 1'b0;
                run  <= (op == OP_TX) || (op == OP_RX);
                if (op == OP_RX) begin
                  dreg     <= shreg;
                  tx_ack_n <= nack;
                end
              end else begin
                bitn <= bitn + 4'd1;
              end
            end
            default: ;
          endcase
        end
      end
    end
  end

  // R6
  irq_on_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> done_irq);

  // R6
  irq_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_irq |=> !done_irq);

  // R8
  busy_cmd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_wr && busy && !finish |=> busy && err);

  // R7
  bad_cmd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_wr && !busy && !legal |=> err && !busy);

  // R11
  sda_scl_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy && (op == OP_TX || op == OP_RX) && !$stable(sda_pull) |-> scl_pull);
endmodule

// File: tb/sim_twi_cmd_master.sv
module sim_twi_cmd_master;
  localparam int QTR = 2;
  localparam logic [3:0] C_NOP = 4'b0000, C_RXA = 4'b0010, C_TX = 4'b0011,
                         C_STOP = 4'b0101, C_RXL = 4'b0110, C_START = 4'b1001;

  typedef struct packed {
    logic [3:0] c;
    logic [7:0] wd;
    logic [7:0] sb;
    logic       sack;
    logic [7:0] ed;
    logic [7:0] es;
    logic [3:0] nst;
    logic [3:0] nsp;
  } vec_t;

  localparam int NV = 10;
  localparam vec_t VEC [NV] = '{
    '{C_START, 8'h00, 8'h00, 1'b0, 8'h00, 8'h30, 4'd1, 4'd0},
    '{C_TX,    8'hA5, 8'h00, 1'b1, 8'hA5, 8'h10, 4'd1, 4'd0},
    '{C_NOP,   8'h00, 8'h00, 1'b0, 8'hA5, 8'h10, 4'd1, 4'd0},
    '{C_TX,    8'h3C, 8'h00, 1'b0, 8'h3C, 8'h30, 4'd1, 4'd0},
    '{C_NOP,   8'h00, 8'h00, 1'b0, 8'h3C, 8'h30, 4'd1, 4'd0},
    '{C_RXA,   8'h00, 8'h96, 1'b0, 8'h96, 8'h20, 4'd1, 4'd0},
    '{C_NOP,   8'h00, 8'h00, 1'b0, 8'h96, 8'h20, 4'd1, 4'd0},
    '{C_RXL,   8'h00, 8'h5B, 1'b0, 8'h5B, 8'h30, 4'd1, 4'd0},
    '{C_NOP,   8'h00, 8'h00, 1'b0, 8'h5B, 8'h30, 4'd1, 4'd0},
    '{C_STOP,  8'h00, 8'h00, 1'b0, 8'h5B, 8'h30, 4'd1, 4'd1}
  };

  logic       clk = 1'b0, rst_n = 1'b0;
  logic       data_wr = 1'b0, ctrl_wr = 1'b0;
  logic [7:0] data_wdata = 8'h00;
  logic [3:0] ctrl_cmd = 4'h0;
  logic [7:0] data_rdata, status;
  logic       done_irq, scl_pull, sda_pull;
  logic       slv_low = 1'b0;
  wire        scl_line = !scl_pull;
  wire        sda_line = !(sda_pull || slv_low);

  always #2.5 clk = ~clk;

  twi_cmd_master #(.QTR_CYC(QTR)) u0 (
    .clk(clk), .rst_n(rst_n), .data_wr(data_wr), .data_wdata(data_wdata),
    .ctrl_wr(ctrl_wr), .ctrl_cmd(ctrl_cmd), .data_rdata(data_rdata),
    .status(status), .done_irq(done_irq), .scl_pull(scl_pull),
    .sda_pull(sda_pull), .sda_in(sda_line));

  int errs = 0, checks = 0;
  int slv_mode = 0, slv_k = 0, cap_n = 9;
  logic slv_ack = 1'b0;
  logic [7:0] slv_byte = 8'h00;
  logic [8:0] cap = 9'h0;
  int starts = 0, stops = 0, irqs = 0, scl_falls = 0, cyc = 0;

  always @(negedge scl_line) begin
    scl_falls = scl_falls + 1;
    if (slv_mode == 2 && slv_k < 8) slv_low = !slv_byte[7 - slv_k];
    else if (slv_mode == 1 && slv_k == 8) slv_low = slv_ack;
    else slv_low = 1'b0;
    slv_k = slv_k + 1;
  end
  always @(posedge scl_line) if (cap_n < 9) begin
    cap = {cap[7:0], sda_line};
    cap_n = cap_n + 1;
  end
  always @(negedge sda_line) if (scl_line === 1'b1) starts = starts + 1;
  always @(posedge sda_line) if (scl_line === 1'b1) stops = stops + 1;
  always @(posedge clk) begin
    cyc = cyc + 1;
    if (done_irq === 1'b1) irqs = irqs + 1;
  end

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks = checks + 1;
    if (act !== exp) begin
      errs = errs + 1;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic do_cmd(input logic [3:0] c);
    @(negedge clk); ctrl_cmd = c; ctrl_wr = 1'b1;
    @(negedge clk); ctrl_wr = 1'b0;
  endtask

  task automatic do_data(input logic [7:0] d);
    @(negedge clk); data_wdata = d; data_wr = 1'b1;
    @(negedge clk); data_wr = 1'b0;
  endtask

  task automatic wait_idle(input string req);
    int n = 0;
    while (status[6] === 1'b1 && n < 4000) begin @(negedge clk); n++; end
    chk(req, "busy released", {31'b0, status[6]}, 32'd0);
  endtask

  task automatic idle_cycles(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic arm_slave(input logic [3:0] c, input logic [7:0] b, input logic a);
    slv_mode = (c == C_TX) ? 1 : ((c == C_RXA || c == C_RXL) ? 2 : 0);
    slv_byte = b; slv_ack = a; slv_k = 0;
    cap_n = (slv_mode != 0) ? 0 : 9;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errs = errs + 1;
    checks = checks + 1;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    starts = 0; stops = 0; irqs = 0; scl_falls = 0;

    // R1 reset state
    chk("R1", "status", {24'b0, status}, 32'h30);
    chk("R1", "data", {24'b0, data_rdata}, 32'h00);
    chk("R1", "irq", {31'b0, done_irq}, 32'd0);
    chk("R1", "scl", {31'b0, scl_line}, 32'd1);
    chk("R1", "sda", {31'b0, sda_line}, 32'd1);

    for (int i = 0; i < NV; i++) begin
      string rq;
      int i0;
      case (VEC[i].c)
        C_START, C_STOP: rq = "R2";
        C_TX:            rq = "R3";
        C_RXA:           rq = "R4";
        C_RXL:           rq = "R5";
        default:         rq = "R10";
      endcase
      if (VEC[i].c == C_TX) do_data(VEC[i].wd);
      arm_slave(VEC[i].c, VEC[i].sb, VEC[i].sack);
      i0 = irqs;
      do_cmd(VEC[i].c);
      wait_idle(rq);
      idle_cycles(2);
      chk(rq, "status", {24'b0, status}, {24'b0, VEC[i].es});
      chk(rq, "data", {24'b0, data_rdata}, {24'b0, VEC[i].ed});
      chk("R6", "irq count", irqs - i0, (VEC[i].c != C_NOP) ? 1 : 0);
      chk("R11", "starts", starts, {28'b0, VEC[i].nst});
      chk("R11", "stops", stops, {28'b0, VEC[i].nsp});
      if (VEC[i].c == C_TX) chk("R3", "bus byte", {24'b0, cap[8:1]}, {24'b0, VEC[i].wd});
      if (VEC[i].c == C_RXA) chk("R4", "master ack bit", {31'b0, cap[0]}, 32'd0);
      if (VEC[i].c == C_RXL) chk("R5", "master nack bit", {31'b0, cap[0]}, 32'd1);
      slv_mode = 0;
    end

    // R7 illegal code while idle
    begin
      int i0, f0;
      i0 = irqs; f0 = scl_falls;
      do_cmd(4'b0111);
      idle_cycles(20);
      chk("R7", "status after illegal", {24'b0, status}, 32'hB0);
      chk("R7", "no irq", irqs - i0, 0);
      chk("R7", "no scl activity", scl_falls - f0, 0);
      do_cmd(C_NOP);
      idle_cycles(2);
      chk("R7", "error cleared", {24'b0, status}, 32'h30);
    end

    // R8 R9 writes during a running transmit
    begin
      int i0;
      do_cmd(C_START);
      wait_idle("R2");
      do_data(8'hC3);
      arm_slave(C_TX, 8'h00, 1'b1);
      i0 = irqs;
      do_cmd(C_TX);
      idle_cycles(10);
      do_data(8'h11);
      do_cmd(C_START);
      chk("R8", "err and busy", {30'b0, status[7:6]}, 32'd3);
      wait_idle("R8");
      idle_cycles(2);
      chk("R8", "status after", {24'b0, status}, 32'h90);
      chk("R8", "byte intact", {24'b0, cap[8:1]}, 32'hC3);
      chk("R9", "data kept", {24'b0, data_rdata}, 32'hC3);
      chk("R6", "one irq", irqs - i0, 1);
      slv_mode = 0;
    end

    // R10 free-running clock and its stop
    begin
      int t0, f0;
      @(negedge scl_line); t0 = cyc;
      @(negedge scl_line);
      chk("R10", "scl period", cyc - t0, 4 * QTR);
      do_cmd(C_NOP);
      idle_cycles(4);
      f0 = scl_falls;
      idle_cycles(40);
      chk("R10", "scl stopped", scl_falls - f0, 0);
      chk("R10", "scl rests high", {31'b0, scl_line}, 32'd1);
      chk("R7", "error cleared by no-op", {24'b0, status}, 32'h10);
    end

    // R2 R10 stop then rest
    begin
      int f0;
      do_cmd(C_STOP);
      wait_idle("R2");
      chk("R2", "stop seen", stops, 2);
      f0 = scl_falls;
      idle_cycles(40);
      chk("R10", "rest after stop", scl_falls - f0, 0);
      chk("R11", "total starts", starts, 2);
    end

    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule